// File: doc/BRIEF.md
# Multi-channel PWM match timer

This block is the core of a pulse-width modulation peripheral. It has one timer/counter, a prescaler, seven match registers and two capture inputs. In timer mode the counter advances once every prescale-limit-plus-one clocks. In edge-counting mode it advances instead on rising, falling or both edges of one of the two capture inputs. Each input passes through a two-flop synchroniser first. When the counter takes a step while its value equals an active match value, that match fires. A firing match can raise an interrupt flag, send the counter back to zero, or stop it.

Six PWM outputs are driven from the match events. Each output runs in single-edge mode, where match 0 starts the pulse and match n ends it. Channels 2 to 6 can instead run in dual-edge mode, where match n-1 starts the pulse and match n ends it. While PWM mode is on, match writes land in shadow registers. A shadow value moves to the active set only at the next counter reset, and only if its latch bit is set, so a period is never cut short by a half-updated configuration.

Software reaches all state through a single-cycle write port and a combinational read port of 32-bit words. The interrupt line is the OR of the pending flags.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset every register reads zero and irq and pwm_o are low. The control word (address 0) keeps only bit 0 (run), bit 1 (hold) and bit 3 (PWM mode), so writing all ones reads back 0x0B.
- R2: While the hold bit is set, the count (address 2) and the prescale count (address 4) stay at zero.
- R3: In timer mode with prescale limit L (address 3), the counter takes one step every L+1 clocks. After K running clocks from hold, the count reads floor(K/(L+1)) mod 2^CNT_W and the prescale count reads K mod (L+1).
- R4: Count-mode word (address 7): bits [1:0] = 0 selects timer mode, 1 rising edges, 2 falling edges, 3 both edges. Bits [3:2] = 0 or 1 select cap_in[0] or cap_in[1], and only the selected input is counted.
- R5: Action word (address 5): for match n, bit 3n raises the flag, bit 3n+1 resets the counter and bit 3n+2 stops it. When match 0 resets the counter, the count runs 0..M0 and then 0 again.
- R6: A stopping match holds the count at its value and clears the run bit. If reset and stop fire together, reset wins: the counter restarts from 0 and run stays set.
- R7: Flags (address 1) are matches 0-3 at bits 0-3, captures 0-1 at bits 4-5, and matches 4-6 at bits 8-10. Writing 1 to a flag clears it. irq is high while any flag is set, and a new event set in the same cycle wins over a clear.
- R8: Capture word (address 6): for input c, bit 3c captures on a rising edge, bit 3c+1 on a falling edge, and bit 3c+2 flags the capture. A selected edge copies the count into address 10+c. An edge of the other polarity changes nothing.
- R9: Match n sits at address 16+n. With PWM mode off, a write takes effect at once. With PWM mode on, a write goes to the shadow and reaches the active match at the next counter reset only if bit n of the latch word (address 9) is set. That bit then clears itself.
- R10: In single-edge mode with period M0 and match M, each period has M+1 high steps when M<M0, none when M=M0, and M0+1 when M>M0. A clear wins over a set in the same step.
- R11: Output word (address 8) bits 2-6 select dual-edge mode for channels 2-6. With matches a (start) and b (end), each period has 0 high steps when a=b, b-a when a<b, and M0+1-(a-b) otherwise.
- R12: pwm_o[n-1] carries channel n. It is low unless PWM mode is on and its enable bit 8+n (address 8) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| cap_in | input | 2 | Asynchronous capture / count inputs |
| irq | output | 1 | OR of all pending flags |
| pwm_o | output | 6 | PWM outputs, channel n on bit n-1 |

## Verification
The bench builds the block with CNT_W = 8 and SYNC_STAGES = 2. The narrow counter makes wrap-around reachable within a few hundred clocks, and it keeps every match value small enough to sweep. With an 8-step period, the single-edge sweep covers every match below, at and above the period. The dual-edge sweep covers all 64 start/end pairs, with expected high counts worked out arithmetically. The prescale limits 0 to 4 and all six count-mode and input-select combinations are each run in full.

// File: rtl/pwmt_pkg.sv
// Shared constants for the PWM match timer: register addresses, writable
// masks, field positions and the counting-mode encoding.
package pwmt_pkg;
    localparam int NUM_MATCH = 7;
    localparam int NUM_CAP   = 2;
    localparam int NUM_PWM   = NUM_MATCH - 1;
    localparam int ADDR_W    = 5;
    localparam int FLAG_W    = 11;
    localparam int ACT_W     = 3 * NUM_MATCH;
    localparam int CAPCFG_W  = 3 * NUM_CAP;
    localparam int OUTCFG_W  = 15;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_FLAG   = 5'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'd2;
    localparam logic [ADDR_W-1:0] A_PLIM   = 5'd3;
    localparam logic [ADDR_W-1:0] A_PCNT   = 5'd4;
    localparam logic [ADDR_W-1:0] A_ACT    = 5'd5;
    localparam logic [ADDR_W-1:0] A_CAPCFG = 5'd6;
    localparam logic [ADDR_W-1:0] A_CMODE  = 5'd7;
    localparam logic [ADDR_W-1:0] A_OUTCFG = 5'd8;
    localparam logic [ADDR_W-1:0] A_LATCH  = 5'd9;
    localparam int                CAP_BASE   = 10;
    localparam int                MATCH_BASE = 16;

    localparam logic [3:0]          CTRL_MASK   = 4'hB;
    localparam logic [FLAG_W-1:0]   FLAG_MASK   = 11'h73F;
    localparam logic [OUTCFG_W-1:0] OUTCFG_MASK = 15'h7E7C;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_HOLD = 1;
    localparam int CTRL_PWM  = 3;
    localparam int CAP_FLAG_BASE = 4;

    typedef enum logic [1:0] {
        CM_TIMER = 2'd0,
        CM_RISE  = 2'd1,
        CM_FALL  = 2'd2,
        CM_BOTH  = 2'd3
    } cnt_mode_e;

    // Flag bit used by match n: low four matches packed, the rest above the captures.
    function automatic int match_flag_pos(input int n);
        return (n < 4) ? n : n + 4;
    endfunction
endpackage

// File: rtl/pwmt_edge_sync.sv
// Synchronises N_IN asynchronous inputs through STAGES flops and reports
// one-cycle rise and fall pulses. Assumes STAGES >= 2.
module pwmt_edge_sync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] in_async,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall
);
    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            logic [STAGES:0] sh;
            // Shift the input through the synchroniser plus one history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-1:0], in_async[i]};
            end
            assign rise[i] =  sh[STAGES-1] & ~sh[STAGES];
            assign fall[i] = ~sh[STAGES-1] &  sh[STAGES];
        end
    endgenerate
endmodule

// File: rtl/pwmt_tick_gen.sv
// Produces the counter step strobe: a prescaler wrap in timer mode, or a
// qualifying edge of the selected input in counting mode. Assumes the edge
// pulses come from pwmt_edge_sync.
module pwmt_tick_gen
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               hold,
    input  cnt_mode_e          mode,
    input  logic               sel,
    input  logic [NUM_CAP-1:0] rise,
    input  logic [NUM_CAP-1:0] fall,
    input  logic [CNT_W-1:0]   limit,
    output logic               tick,
    output logic [CNT_W-1:0]   pcnt
);
    logic edge_hit;
    logic wrap;

    // Pick the edges that count in the selected counting mode.
    always_comb begin
        edge_hit = (mode[0] & rise[sel]) | (mode[1] & fall[sel]);
        wrap     = (pcnt >= limit);
    end

    assign tick = run & ~hold & ((mode == CM_TIMER) ? wrap : edge_hit);

    // Prescale counter: runs 0..limit in timer mode, cleared by hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)                pcnt <= '0;
        else if (run && mode == CM_TIMER)  pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/pwmt_out_stage.sv
// Set/clear output flops for the PWM channels. Channel k+1 drives pwm[k];
// a clear wins over a set in the same step. Assumes hit[] are one-cycle
// match events and dual[0] is tied low.
module pwmt_out_stage #(
    parameter int NUM_CH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [NUM_CH:0] hit,
    input  logic [NUM_CH-1:0] dual,
    input  logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] pwm
);
    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            logic st;
            logic set_ev;
            assign set_ev = dual[k] ? hit[k] : hit[0];
            // Track the channel level from its start and end matches.
            always_ff @(posedge clk) begin
                if (!rst_n || !active) st <= 1'b0;
                else if (hit[k+1])     st <= 1'b0;
                else if (set_ev)       st <= 1'b1;
            end
            assign pwm[k] = st & en[k];
        end
    endgenerate
endmodule

// File: rtl/pwm_match_timer.sv
// Top of the PWM match timer: register file, counter, match compare with
// shadow/active match values, capture and interrupt flags. Assumes a
// single-cycle write port and a combinational read of addr.
module pwm_match_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_CAP-1:0] cap_in,
    output logic               irq,
    output logic [NUM_PWM-1:0] pwm_o
);
    logic [3:0]          ctrl_q;
    logic [FLAG_W-1:0]   flag_q, flag_set;
    logic [CNT_W-1:0]    tc_q, plim_q, pcnt_w;
    logic [ACT_W-1:0]    act_q;
    logic [CAPCFG_W-1:0] capcfg_q;
    logic [3:0]          cmode_q;
    logic [OUTCFG_W-1:0] outcfg_q;
    logic [NUM_MATCH-1:0] latch_q;
    logic [CNT_W-1:0]    cap_v [NUM_CAP];
    logic [CNT_W-1:0]    shadow_v [NUM_MATCH];

    logic [NUM_MATCH-1:0] hit, rst_en, stop_en, irqm_en, xfer, wr_match;
    logic [NUM_CAP-1:0]   rise, fall, cap_evt, cap_irq;
    logic [NUM_PWM-1:0]   dual_v, en_v;
    logic tick_w, rst_evt, stop_evt, hold_w, run_w, pwm_mode, irq_hit_any;
    logic wr_ctrl, wr_latch;

    assign hold_w   = ctrl_q[CTRL_HOLD];
    assign run_w    = ctrl_q[CTRL_RUN];
    assign pwm_mode = ctrl_q[CTRL_PWM];
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_latch = wr_en && (addr == A_LATCH);

    pwmt_edge_sync #(.N_IN(NUM_CAP), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .in_async(cap_in), .rise(rise), .fall(fall)
    );

    pwmt_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run_w), .hold(hold_w),
        .mode(cnt_mode_e'(cmode_q[1:0])), .sel(cmode_q[2]),
        .rise(rise), .fall(fall), .limit(plim_q), .tick(tick_w), .pcnt(pcnt_w)
    );

    generate
        for (genvar n = 0; n < NUM_MATCH; n++) begin : g_match
            logic [CNT_W-1:0] shd, act;
            assign irqm_en[n]  = act_q[3*n];
            assign rst_en[n]   = act_q[3*n+1];
            assign stop_en[n]  = act_q[3*n+2];
            assign wr_match[n] = wr_en && (addr == ADDR_W'(MATCH_BASE + n));
            assign hit[n]      = tick_w && (tc_q == act);
            assign xfer[n]     = (rst_evt || hold_w) && latch_q[n];
            assign shadow_v[n] = shd;
            // Shadow takes every write; active takes it at once outside PWM mode or on a latched reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shd <= '0;
                    act <= '0;
                end else begin
                    if (wr_match[n]) shd <= wdata[CNT_W-1:0];
                    if (wr_match[n] && !pwm_mode) act <= wdata[CNT_W-1:0];
                    else if (xfer[n])             act <= shd;
                end
            end
        end

        for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
            logic [CNT_W-1:0] val;
            assign cap_evt[c] = (rise[c] & capcfg_q[3*c]) | (fall[c] & capcfg_q[3*c+1]);
            assign cap_irq[c] = cap_evt[c] & capcfg_q[3*c+2];
            assign cap_v[c]   = val;
            // Copy the count on a selected edge.
            always_ff @(posedge clk) begin
                if (!rst_n)          val <= '0;
                else if (cap_evt[c]) val <= tc_q;
            end
        end

        for (genvar k = 0; k < NUM_PWM; k++) begin : g_outcfg
            assign dual_v[k] = outcfg_q[k+1];
            assign en_v[k]   = outcfg_q[k+9];
        end
    endgenerate

    assign rst_evt     = |(hit & rst_en);
    assign stop_evt    = |(hit & stop_en) && !rst_evt;
    assign irq_hit_any = |(hit & irqm_en);

    // Gather the flag bits raised this cycle.
    always_comb begin
        flag_set = '0;
        for (int n = 0; n < NUM_MATCH; n++) flag_set[match_flag_pos(n)] = hit[n] & irqm_en[n];
        for (int c = 0; c < NUM_CAP; c++)   flag_set[CAP_FLAG_BASE + c]  = cap_irq[c];
    end

    // Timer/counter: cleared by hold or a resetting match, frozen by a stopping match.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tc_q <= '0;
        else if (hold_w || rst_evt)     tc_q <= '0;
        else if (tick_w && !stop_evt)   tc_q <= tc_q + 1'b1;
    end

    // Configuration words, control run-bit clearing and latch-bit self clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0; plim_q <= '0; act_q <= '0; capcfg_q <= '0;
            cmode_q <= '0; outcfg_q <= '0; latch_q <= '0;
        end else begin
            if (wr_ctrl)       ctrl_q <= wdata[3:0] & CTRL_MASK;
            else if (stop_evt) ctrl_q[CTRL_RUN] <= 1'b0;
            if (wr_en && addr == A_PLIM)   plim_q   <= wdata[CNT_W-1:0];
            if (wr_en && addr == A_ACT)    act_q    <= wdata[ACT_W-1:0];
            if (wr_en && addr == A_CAPCFG) capcfg_q <= wdata[CAPCFG_W-1:0];
            if (wr_en && addr == A_CMODE)  cmode_q  <= wdata[3:0];
            if (wr_en && addr == A_OUTCFG) outcfg_q <= wdata[OUTCFG_W-1:0] & OUTCFG_MASK;
            if (wr_latch) latch_q <= wdata[NUM_MATCH-1:0];
            else          latch_q <= latch_q & ~xfer;
        end
    end

    // Interrupt flags: write one to clear, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else flag_q <= (flag_q & ~((wr_en && addr == A_FLAG) ? wdata[FLAG_W-1:0] : '0))
                       | (flag_set & FLAG_MASK);
    end

    assign irq = |flag_q;

    pwmt_out_stage #(.NUM_CH(NUM_PWM)) u_out (
        .clk(clk), .rst_n(rst_n), .active(pwm_mode), .hit(hit),
        .dual(dual_v), .en(en_v), .pwm(pwm_o)
    );

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = 32'(ctrl_q);
            A_FLAG:   rdata = 32'(flag_q);
            A_COUNT:  rdata = 32'(tc_q);
            A_PLIM:   rdata = 32'(plim_q);
            A_PCNT:   rdata = 32'(pcnt_w);
            A_ACT:    rdata = 32'(act_q);
            A_CAPCFG: rdata = 32'(capcfg_q);
            A_CMODE:  rdata = 32'(cmode_q);
            A_OUTCFG: rdata = 32'(outcfg_q);
            A_LATCH:  rdata = 32'(latch_q);
            default: begin
                for (int c = 0; c < NUM_CAP; c++)
                    if (addr == ADDR_W'(CAP_BASE + c)) rdata = 32'(cap_v[c]);
                for (int n = 0; n < NUM_MATCH; n++)
                    if (addr == ADDR_W'(MATCH_BASE + n)) rdata = 32'(shadow_v[n]);
            end
        endcase
    end
endmodule

// File: rtl/pwmt_timer_chk.sv
// Assertion checker for pwm_match_timer, attached by bind. Relates the
// counter, control and flag state across clock edges.
module pwmt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold,
    input logic             run,
    input logic             tick,
    input logic             rst_evt,
    input logic             stop_evt,
    input logic             wr_ctrl,
    input logic             wr_latch,
    input logic             irq_hit_any,
    input logic             irq,
    input logic [CNT_W-1:0] tc,
    input logic [CNT_W-1:0] pcnt,
    input logic [6:0]       latch
);
    // R2
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tc == '0 && pcnt == '0));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && !rst_evt && !stop_evt) |=> tc == CNT_W'($past(tc) + 1'b1));

    // R5
    match_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> tc == '0);

    // R6
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !wr_ctrl) |=> (!run && $stable(tc)));

    // R7
    flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hit_any |=> irq);

    // R9
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt && !hold && !wr_latch) |=> latch == '0);
endmodule

bind pwm_match_timer pwmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold(hold_w), .run(run_w), .tick(tick_w),
    .rst_evt(rst_evt), .stop_evt(stop_evt), .wr_ctrl(wr_ctrl), .wr_latch(wr_latch),
    .irq_hit_any(irq_hit_any), .irq(irq), .tc(tc_q), .pcnt(pcnt_w), .latch(latch_q)
);

// File: tb/pwm_match_timer_bench.sv
// Self-checking bench for pwm_match_timer built with an 8-bit counter.
module pwm_match_timer_bench;
    localparam int CNT_W = 8;
    localparam int PER   = 8;   // PWM period in steps (match 0 = 7)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  cap_in = '0;
    logic        irq;
    logic [5:0]  pwm_o;

    int n_tests = 0;
    int n_fail  = 0;

    pwm_match_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_pwm_match_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .irq(irq), .pwm_o(pwm_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int ch, output int hi);
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
        end
    endtask

    task automatic pulse(input int ch);
        cap_in[ch] = 1'b1; idle(4);
        cap_in[ch] = 1'b0; idle(4);
    endtask

    // Hold, then run with the given control word.
    task automatic restart(input logic [31:0] ctrl);
        wr(5'd0, 32'h2);
        wr(5'd0, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi, exp;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state and control mask
        rd(5'd0, d); chk("R1 ctrl", d, 0);
        rd(5'd1, d); chk("R1 flags", d, 0);
        rd(5'd2, d); chk("R1 count", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pwm_o", pwm_o, 0);
        wr(5'd0, 32'hFFFF_FFFF);
        rd(5'd0, d); chk("R1 ctrl mask", d, 32'h0B);

        // R2 hold keeps counter and prescaler at zero
        wr(5'd0, 32'h3);
        idle(20);
        rd(5'd2, d); chk("R2 count", d, 0);
        rd(5'd4, d); chk("R2 prescale", d, 0);

        // R3 prescale sweep
        for (int pr = 0; pr <= 4; pr++) begin
            wr(5'd3, pr);
            restart(32'h1);
            idle(23);
            rd(5'd2, d); chk("R3 count", d, 23 / (pr + 1));
            rd(5'd4, d); chk("R3 prescale", d, 23 % (pr + 1));
        end
        // R3 wrap of the 8-bit counter
        wr(5'd3, 0);
        restart(32'h1);
        idle(300);
        rd(5'd2, d); chk("R3 wrap", d, 300 % 256);

        // R4 edge counting: 5 pulses on input 0, 3 on input 1
        for (int m = 1; m <= 3; m++) begin
            for (int s = 0; s <= 1; s++) begin
                wr(5'd7, (s << 2) | m);
                restart(32'h1);
                for (int p = 0; p < 5; p++) pulse(0);
                for (int p = 0; p < 3; p++) pulse(1);
                idle(6);
                exp = (s == 1) ? 3 : 5;
                if (m == 3) exp = exp * 2;
                rd(5'd2, d); chk("R4 edge count", d, exp);
            end
        end
        wr(5'd7, 0);

        // R5 period from match 0 (timer-mode write takes effect at once, R9)
        wr(5'd5, 32'h2);
        wr(5'd16, 9);
        restart(32'h1);
        idle(37);
        rd(5'd2, d); chk("R5 period count", d, 37 % 10);

        // R6 stop on match 3 with flag (R7 bit 3)
        wr(5'd5, (1 << 11) | (1 << 9));
        wr(5'd19, 20);
        restart(32'h1);
        idle(40);
        rd(5'd2, d); chk("R6 stopped count", d, 20);
        rd(5'd0, d); chk("R6 run cleared", d, 0);
        rd(5'd1, d); chk("R7 match3 flag", d, 32'h8);
        chk("R7 irq set", irq, 1);
        wr(5'd1, 32'h8);
        rd(5'd1, d); chk("R7 write-one clear", d, 0);
        chk("R7 irq clear", irq, 0);

        // R6 reset beats stop on match 0
        wr(5'd5, 32'h6);
        restart(32'h1);
        idle(35);
        rd(5'd0, d); chk("R6 run kept", d, 32'h1);
        rd(5'd2, d); chk("R6 restart count", d, 35 % 10);

        // R7 match 5 flag lands on bit 9
        wr(5'd5, (1 << 1) | (1 << 15));
        wr(5'd21, 4);
        restart(32'h1);
        idle(20);
        rd(5'd1, d); chk("R7 match5 flag", d, 32'h200);
        wr(5'd5, 0);
        wr(5'd1, 32'h7FF);
        rd(5'd1, d); chk("R7 cleared", d, 0);

        // R8 capture: counter frozen at 20 by match 3 stop
        wr(5'd5, 1 << 11);
        wr(5'd6, 32'h15);
        restart(32'h1);
        idle(40);
        cap_in[0] = 1'b1; idle(6);
        rd(5'd10, d); chk("R8 capture0 rise", d, 20);
        rd(5'd1, d);  chk("R8 capture0 flag", d, 32'h10);
        cap_in[1] = 1'b1; idle(6);
        rd(5'd11, d); chk("R8 capture1 ignores rise", d, 0);
        rd(5'd1, d);  chk("R8 no capture1 flag", d, 32'h10);
        cap_in[1] = 1'b0; idle(6);
        rd(5'd11, d); chk("R8 capture1 fall", d, 20);
        cap_in[0] = 1'b0; idle(6);
        wr(5'd6, 0);
        wr(5'd1, 32'h7FF);

        // PWM setup: period 8 steps, ch1 single, ch2 dual, both enabled
        wr(5'd0, 32'h2);
        wr(5'd5, 32'h2);
        wr(5'd16, PER - 1);
        wr(5'd8, 32'h604);
        wr(5'd0, 32'h9);

        // R10 single-edge sweep on channel 1 (shadow + latch, R9)
        for (int m = 0; m <= 9; m++) begin
            wr(5'd17, m);
            wr(5'd9, 32'h2);
            idle(3 * PER);
            measure(0, hi);
            exp = (m < PER - 1) ? m + 1 : ((m == PER - 1) ? 0 : PER);
            chk("R10 single-edge high steps", hi, exp);
        end

        // R9 deferred update needs the latch bit
        wr(5'd17, 2); wr(5'd9, 32'h2); idle(3 * PER);
        wr(5'd17, 5); idle(3 * PER);
        measure(0, hi); chk("R9 no latch keeps old match", hi, 3);
        wr(5'd9, 32'h2);
        rd(5'd9, d); chk("R9 latch bit pending", d, 32'h2);
        idle(3 * PER);
        measure(0, hi); chk("R9 latched match applied", hi, 6);
        rd(5'd9, d); chk("R9 latch bit self-cleared", d, 0);

        // R11 dual-edge sweep on channel 2
        for (int a = 0; a < PER; a++) begin
            for (int b = 0; b < PER; b++) begin
                wr(5'd17, a);
                wr(5'd18, b);
                wr(5'd9, 32'h6);
                idle(3 * PER);
                measure(1, hi);
                exp = (a == b) ? 0 : ((a < b) ? b - a : PER - (a - b));
                chk("R11 dual-edge high steps", hi, exp);
            end
        end

        // R12 output gating
        wr(5'd17, 2); wr(5'd18, 5); wr(5'd9, 32'h6);
        idle(3 * PER);
        measure(1, hi); chk("R11 dual-edge 2..5", hi, 3);
        wr(5'd8, 32'h404);
        idle(PER);
        measure(0, hi); chk("R12 channel 1 disabled", hi, 0);
        wr(5'd0, 32'h1);
        idle(PER);
        measure(1, hi); chk("R12 PWM mode off", hi, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule